// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

A purely combinational arithmetic and logic unit for a small 8-bit microcontroller datapath. Each cycle the core presents an operation code, two operands and the current status byte. The unit returns a result, a strobe that says whether the result should be written back, and the next status byte. Carry, half-carry, signed overflow, negative, zero and sign flags are all derived here. The two upper status bits, the transfer bit and the interrupt enable, are carried through untouched.

The unit covers the following operations:
- Plain and carry-in addition.
- Plain and borrow-in subtraction.
- Plain and borrow-in comparison.
- Bitwise AND, OR and XOR.
- Decrement.
- Logical shift left and rotate left through carry.

Subtraction is formed as `a + ~b + cin`. A missing carry out is reported as a borrow. The borrow-in forms keep the zero flag set only when it was already set. This lets a compare over several bytes give a correct overall equality. Comparisons update the flags but never request a write-back.

Top module: `alu8_core`

## Requirements
- R1: The status byte layout is C=bit0, Z=bit1, N=bit2, V=bit3, S=bit4, H=bit5, T=bit6, I=bit7. Bits 7:6 of `sreg_o` always equal bits 7:6 of `sreg_i`.
- R2: Op 0 (add) and op 1 (add with carry, cin = old C) produce `a+b+cin`. C is the carry out of bit 7, H is the carry out of bit 3, and V is the carry into bit 7 xor the carry out of bit 7. Write-enable is 1.
- R3: Op 2 (subtract, cin=1) and op 3 (subtract with borrow, cin = not old C) produce `a + ~b + cin`. C is the inverted carry out of bit 7 and H is the inverted carry out of bit 3. V is the carry into bit 7 xor the carry out of bit 7. Write-enable is 1.
- R4: For op 3 and op 5, Z is 1 only when the result is zero and the incoming Z was 1. For all other arithmetic ops, Z is 1 exactly on a zero result.
- R5: Op 4 (compare) and op 5 (compare with borrow) set H, S, V, N, Z and C exactly as op 2 and op 3 respectively would. Write-enable is 0.
- R6: Op 6 (AND), op 7 (OR) and op 8 (XOR) clear V, set Z on a zero result, and leave C and H unchanged. Write-enable is 1.
- R7: Op 9 (decrement) produces `a-1`. V is 1 only when `a` was 0x80. C and H are left unchanged.
- R8: Op 10 (shift left) produces `{a[6:0],0}` and op 11 (rotate left) produces `{a[6:0],old C}`. For both, C = old bit 7, H = old bit 3 and V = old bit 7 xor old bit 6.
- R9: For every supported op, N equals bit 7 of the result and S equals N xor V.
- R10: Op codes 12 to 15 leave the status byte unchanged (`sreg_o == sreg_i`) and drive write-enable to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (0..11 supported) |
| a_i | input | 8 | First operand (destination value) |
| b_i | input | 8 | Second operand (source or immediate) |
| sreg_i | input | 8 | Current status byte |
| res_o | output | 8 | Operation result |
| we_o | output | 1 | Result write-back request |
| sreg_o | output | 8 | Next status byte |

## Verification
The two behaviours that coincide are the borrow-chained zero rule and the write suppression of a compare. A compare-with-borrow is evaluated in one cycle both to decide the write strobe and to fold the old Z into the new Z. The bench provokes this by issuing op 5 with equal operands under each incoming Z value, and once with C set so the result wraps to 0xFF. It then judges that write-enable stays low while Z follows only the incoming Z and the zero test together. Decrement and the logical ops are also driven with C and H preset, to show that those bits survive while V and Z change in the same evaluation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CMP = 4'd4,
    OP_CPC = 4'd5,
    OP_AND = 4'd6,
    OP_OR  = 4'd7,
    OP_XOR = 4'd8,
    OP_DEC = 4'd9,
    OP_LSL = 4'd10,
    OP_ROL = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

  // status bit positions (R1)
  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_Z = 1;
  localparam int unsigned FLG_N = 2;
  localparam int unsigned FLG_V = 3;
  localparam int unsigned FLG_S = 4;
  localparam int unsigned FLG_H = 5;
  localparam int unsigned FLG_T = 6;
  localparam int unsigned FLG_I = 7;
  localparam int unsigned SREG_W = 8;

  function automatic logic op_known(input logic [3:0] op);
    return op <= OP_ROL;
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              inv_b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              co_o,
  output logic              hco_o,
  output logic              msb_cin_o
);
  localparam int unsigned NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] b_eff;
  logic [NIB_W:0]    nib_sum;
  logic [DATA_W-1:0] low_sum;
  logic [DATA_W:0]   full_sum;

  assign b_eff = inv_b_i ? ~b_i : b_i;

  // separate partial sums expose the internal carries
  assign nib_sum  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                  + {{NIB_W{1'b0}}, cin_i};
  assign low_sum  = {1'b0, a_i[DATA_W-2:0]} + {1'b0, b_eff[DATA_W-2:0]}
                  + {{(DATA_W-1){1'b0}}, cin_i};
  assign full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_i};

  assign sum_o     = full_sum[DATA_W-1:0];
  assign co_o      = full_sum[DATA_W];
  assign hco_o     = nib_sum[NIB_W];
  assign msb_cin_o = low_sum[DATA_W-1];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic_sel_e        sel_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              rotate_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              h_o,
  output logic              v_o
);
  localparam int unsigned NIB_W = DATA_W / 2;

  assign res_o = {a_i[DATA_W-2:0], rotate_i & cin_i};
  assign c_o   = a_i[DATA_W-1];
  assign h_o   = a_i[NIB_W-1];
  assign v_o   = a_i[DATA_W-1] ^ a_i[DATA_W-2];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SREG_W-1:0] sreg_i,
  output logic [DATA_W-1:0] res_o,
  output logic              we_o,
  output logic [SREG_W-1:0] sreg_o
);
  localparam logic [DATA_W-1:0] ONE_VAL = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic c_old, z_old;
  assign c_old = sreg_i[FLG_C];
  assign z_old = sreg_i[FLG_Z];

  // class decode
  logic is_add, is_sub, is_dec, is_chain, is_cmp, is_logic, is_shift;
  assign is_add   = (op_i == OP_ADD) || (op_i == OP_ADC);
  assign is_sub   = (op_i == OP_SUB) || (op_i == OP_SBC) ||
                    (op_i == OP_CMP) || (op_i == OP_CPC);
  assign is_dec   = (op_i == OP_DEC);
  assign is_chain = (op_i == OP_SBC) || (op_i == OP_CPC);
  assign is_cmp   = (op_i == OP_CMP) || (op_i == OP_CPC);
  assign is_logic = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR);
  assign is_shift = (op_i == OP_LSL) || (op_i == OP_ROL);

  // shared adder: add, subtract/compare and decrement
  logic [DATA_W-1:0] add_b, add_sum;
  logic              add_inv, add_cin, add_co, add_hco, add_mcin;

  always_comb begin
    add_b   = is_dec ? ONE_VAL : b_i;
    add_inv = is_sub | is_dec;
    if (is_dec)                 add_cin = 1'b1;
    else if (op_i == OP_ADC)    add_cin = c_old;
    else if (is_chain)          add_cin = ~c_old;
    else                        add_cin = is_sub;
  end

  alu8_addsub #(.DATA_W(DATA_W)) i_addsub (
    .a_i       (a_i),
    .b_i       (add_b),
    .inv_b_i   (add_inv),
    .cin_i     (add_cin),
    .sum_o     (add_sum),
    .co_o      (add_co),
    .hco_o     (add_hco),
    .msb_cin_o (add_mcin)
  );

  logic_sel_e        lg_sel;
  logic [DATA_W-1:0] lg_res;

  always_comb begin
    if (op_i == OP_OR)       lg_sel = LG_OR;
    else if (op_i == OP_XOR) lg_sel = LG_XOR;
    else                     lg_sel = LG_AND;
  end

  alu8_logic #(.DATA_W(DATA_W)) i_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (lg_sel),
    .res_o (lg_res)
  );

  logic [DATA_W-1:0] sh_res;
  logic              sh_c, sh_h, sh_v;

  alu8_shift #(.DATA_W(DATA_W)) i_shift (
    .a_i      (a_i),
    .rotate_i (op_i == OP_ROL),
    .cin_i    (c_old),
    .res_o    (sh_res),
    .c_o      (sh_c),
    .h_o      (sh_h),
    .v_o      (sh_v)
  );

  // result and flag assembly
  logic [DATA_W-1:0] res;
  logic              zero, known;
  logic              f_c, f_h, f_v, f_z, f_n;

  always_comb begin
    res = '0;
    f_c = c_old;
    f_h = sreg_i[FLG_H];
    f_v = sreg_i[FLG_V];
    if (is_add) begin
      res = add_sum;
      f_c = add_co;
      f_h = add_hco;
      f_v = add_mcin ^ add_co;
    end else if (is_sub) begin
      res = add_sum;
      f_c = ~add_co;   // borrow
      f_h = ~add_hco;
      f_v = add_mcin ^ add_co;
    end else if (is_dec) begin
      res = add_sum;
      f_v = (a_i == MIN_NEG);
    end else if (is_logic) begin
      res = lg_res;
      f_v = 1'b0;
    end else if (is_shift) begin
      res = sh_res;
      f_c = sh_c;
      f_h = sh_h;
      f_v = sh_v;
    end
  end

  assign known = op_known(op_i);
  assign zero  = (res == '0);
  assign f_z   = is_chain ? (zero & z_old) : zero;
  assign f_n   = res[DATA_W-1];

  always_comb begin
    sreg_o = sreg_i;
    if (known) begin
      sreg_o[FLG_C] = f_c;
      sreg_o[FLG_Z] = f_z;
      sreg_o[FLG_N] = f_n;
      sreg_o[FLG_V] = f_v;
      sreg_o[FLG_S] = f_n ^ f_v;
      sreg_o[FLG_H] = f_h;
    end
  end

  assign res_o = res;
  assign we_o  = known & ~is_cmp;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [SREG_W-1:0] sreg_i,
  input logic [DATA_W-1:0] res_o,
  input logic              we_o,
  input logic [SREG_W-1:0] sreg_o
);
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  always_comb begin
    // R1
    ti_pass_chk: assert (sreg_o[FLG_I:FLG_T] == sreg_i[FLG_I:FLG_T]);
    // R9
    if (op_i <= 4'd11) begin
      sign_rel_chk: assert (sreg_o[FLG_S] == (sreg_o[FLG_N] ^ sreg_o[FLG_V]) &&
                            sreg_o[FLG_N] == res_o[DATA_W-1]);
    end
    // R5
    if (op_i == 4'd4 || op_i == 4'd5) begin
      cmp_no_write_chk: assert (!we_o);
    end
    // R4
    if ((op_i == 4'd3 || op_i == 4'd5) && !sreg_i[FLG_Z]) begin
      chain_z_chk: assert (!sreg_o[FLG_Z]);
    end
    // R7
    if (op_i == 4'd9) begin
      dec_keep_chk: assert (sreg_o[FLG_C] == sreg_i[FLG_C] &&
                            sreg_o[FLG_H] == sreg_i[FLG_H] &&
                            sreg_o[FLG_V] == (a_i == MIN_NEG));
    end
    // R6
    if (op_i >= 4'd6 && op_i <= 4'd8) begin
      logic_flags_chk: assert (!sreg_o[FLG_V] && we_o &&
                               sreg_o[FLG_C] == sreg_i[FLG_C] &&
                               sreg_o[FLG_H] == sreg_i[FLG_H]);
    end
    // R10
    if (op_i > 4'd11) begin
      bad_op_chk: assert (sreg_o == sreg_i && !we_o);
    end
  end
endmodule

bind alu8_core alu8_chk #(.DATA_W(DATA_W)) i_chk (
  .op_i   (op_i),
  .a_i    (a_i),
  .sreg_i (sreg_i),
  .res_o  (res_o),
  .we_o   (we_o),
  .sreg_o (sreg_o)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0, sreg_i = '0;
  logic [7:0] res_o, sreg_o;
  logic       we_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core i_alu8_core (
    .op_i   (op_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .sreg_i (sreg_i),
    .res_o  (res_o),
    .we_o   (we_o),
    .sreg_o (sreg_o)
  );

  task automatic apply(input string tag, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] s_in, input logic chk_res,
                       input logic [7:0] r_exp, input logic we_exp, input logic [7:0] s_exp);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; sreg_i = s_in;
    @(posedge clk);
    #1;
    n_chk++;
    if ((chk_res && res_o !== r_exp) || we_o !== we_exp || sreg_o !== s_exp) begin
      n_err++;
      $display("FAIL %s: op=%0d a=%h b=%h res=%h/%h we=%b/%b sreg=%h/%h (actual/expected)",
               tag, op, a, b, res_o, r_exp, we_o, we_exp, sreg_o, s_exp);
    end
  endtask

  task automatic t_reset;
    apply("R2 idle zero add", 4'd0, 8'h00, 8'h00, 8'h00, 1, 8'h00, 1, 8'h02);
  endtask

  task automatic t_add;
    apply("R1 R2 half carry, T/I kept", 4'd0, 8'h0F, 8'h01, 8'hC0, 1, 8'h10, 1, 8'hE0);
    apply("R2 R9 signed overflow", 4'd0, 8'h7F, 8'h01, 8'h00, 1, 8'h80, 1, 8'h2C);
    apply("R2 carry wrap", 4'd0, 8'hFF, 8'h01, 8'h00, 1, 8'h00, 1, 8'h23);
    apply("R2 adc carry in", 4'd1, 8'h10, 8'h20, 8'h01, 1, 8'h31, 1, 8'h00);
  endtask

  task automatic t_sub;
    apply("R3 borrow out", 4'd2, 8'h00, 8'h01, 8'h00, 1, 8'hFF, 1, 8'h35);
    apply("R3 overflow", 4'd2, 8'h80, 8'h01, 8'h00, 1, 8'h7F, 1, 8'h38);
    apply("R3 sbc borrow in", 4'd3, 8'h05, 8'h04, 8'h03, 1, 8'h00, 1, 8'h02);
  endtask

  task automatic t_chain;
    apply("R4 sbc zero, old Z clear", 4'd3, 8'h05, 8'h05, 8'h00, 1, 8'h00, 1, 8'h00);
    apply("R4 sbc zero, old Z set", 4'd3, 8'h05, 8'h05, 8'h02, 1, 8'h00, 1, 8'h02);
  endtask

  task automatic t_compare;
    apply("R5 cmp less", 4'd4, 8'h10, 8'h20, 8'h00, 1, 8'hF0, 0, 8'h15);
    apply("R5 R4 cpc wrap with borrow", 4'd5, 8'h00, 8'h00, 8'h03, 1, 8'hFF, 0, 8'h35);
    apply("R5 R4 cpc equal, old Z clear", 4'd5, 8'h12, 8'h12, 8'h00, 1, 8'h00, 0, 8'h00);
    apply("R5 R4 cpc equal, old Z set", 4'd5, 8'h12, 8'h12, 8'h02, 1, 8'h00, 0, 8'h02);
  endtask

  task automatic t_logic;
    apply("R6 and keeps C,H clears V", 4'd6, 8'hF0, 8'h8F, 8'h29, 1, 8'h80, 1, 8'h35);
    apply("R6 or zero", 4'd7, 8'h00, 8'h00, 8'h21, 1, 8'h00, 1, 8'h23);
    apply("R6 xor self", 4'd8, 8'h5A, 8'h5A, 8'h00, 1, 8'h00, 1, 8'h02);
    apply("R6 R9 xor negative", 4'd8, 8'h0F, 8'hF0, 8'h00, 1, 8'hFF, 1, 8'h14);
  endtask

  task automatic t_dec;
    apply("R7 dec 0x80", 4'd9, 8'h80, 8'h55, 8'h21, 1, 8'h7F, 1, 8'h39);
    apply("R7 dec to zero", 4'd9, 8'h01, 8'h00, 8'h00, 1, 8'h00, 1, 8'h02);
    apply("R7 dec wrap", 4'd9, 8'h00, 8'h00, 8'h00, 1, 8'hFF, 1, 8'h14);
  endtask

  task automatic t_shift;
    apply("R8 lsl 0x88", 4'd10, 8'h88, 8'h00, 8'h00, 1, 8'h10, 1, 8'h39);
    apply("R8 lsl ignores C", 4'd10, 8'hC0, 8'h00, 8'h01, 1, 8'h80, 1, 8'h15);
    apply("R8 rol inserts C", 4'd11, 8'h40, 8'h00, 8'h01, 1, 8'h81, 1, 8'h0C);
    apply("R8 rol zero", 4'd11, 8'h00, 8'h00, 8'h00, 1, 8'h00, 1, 8'h02);
  endtask

  task automatic t_bad;
    apply("R10 op 12", 4'd12, 8'h12, 8'h34, 8'hA5, 0, 8'h00, 0, 8'hA5);
    apply("R10 op 15", 4'd15, 8'hFF, 8'h01, 8'h5A, 0, 8'h00, 0, 8'h5A);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_add();
    t_sub();
    t_chain();
    t_compare();
    t_logic();
    t_dec();
    t_shift();
    t_bad();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule